// File: doc/BRIEF.md
# Network Activity LED Controller

This block turns the state of a 10 Mb/s Ethernet port into a single status LED level. It takes five inputs: the selected medium (twisted pair or attachment-unit), the link state, a transmit-busy flag, carrier sense and the collision input. From these it chooses one of three outputs: a steady low, a steady high, or a 10 Hz square wave. With twisted pair, a good idle link gives a low level and a failed link gives a high level. With the attachment-unit medium, idle gives a high level. Any transmit or carrier activity makes the LED blink.

A small internal prescaler derives the blink rate from the system clock frequency. A second counter watches the collision input. When collision stays asserted past a time limit, the block treats the network as faulty and holds the LED high until collision drops. Once blinking has started, the current half-period always runs to completion, so even a short frame gives a blink that can be seen.

The control is a four-state machine. DARK gives a low LED and LIT gives a high LED. FLASH blinks. JAM holds the LED high because of a stuck collision. The transitions are:
- start: enter FLASH from DARK, LIT or JAM on activity.
- tail: leave FLASH only at the end of a half-period.
- settle: go to DARK or LIT from the medium and link.
- jam: enter JAM from any state when collision is stuck.
- release: leave JAM after collision clears.

Top module: `act_led_ctrl`

## Requirements
- R1: While `rst` is sampled high, the LED is driven high and both counters clear. The state is LIT.
- R2: With `media_tp`=1 (twisted pair) and `link_ok`=1, and with `tx_busy`, `crs` and the blink all inactive, `led` is 0 from the next edge.
- R3: With `media_tp`=1, `link_ok`=0 and no activity, `led` is 1 from the next edge.
- R4: With `media_tp`=0 (attachment-unit) and no activity, `led` is 1 from the next edge, whatever the value of `link_ok`.
- R5: When `tx_busy` or `crs` is sampled high while not blinking, the block enters FLASH. `led` inverts at that same edge, so blinking starts at once.
- R6: In FLASH, `led` inverts every HALF_CYC = CLK_HZ/(2*BLINK_HZ) cycles and holds steady in between. This gives a 10 Hz square wave by default.
- R7: After `col` has been sampled high on STUCK_CYC = (CLK_HZ/1000)*STUCK_US/1000 consecutive edges, `led` is 1 from the following edge. This holds whatever the activity.
- R8: The JAM hold ends at the edge after the first edge that samples `col` low. The block then follows R2 to R5 again.
- R9: When activity stops during FLASH, blinking continues until the running half-period ends. At that edge the LED takes its idle level.
- R10: A collision burst shorter than STUCK_CYC edges has no effect on the LED pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| media_tp | input | 1 | 1 = twisted-pair medium, 0 = attachment-unit medium |
| link_ok | input | 1 | Twisted-pair link good |
| tx_busy | input | 1 | Station is transmitting a frame |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision indication |
| led | output | 1 | LED drive level |

## Verification
Every result comes out of one register stage: `led` reflects the inputs sampled at the edge just before it. The exception is the collision path. The stuck flag shows only after the STUCK_CYC-th high sample, so the high level is due one edge later. Release takes two edges after the first low sample. A behavioural model in the bench advances at each rising edge with the same sampled inputs. Its expected level is compared with `led` on every falling edge. Each comparison is tagged with the requirement that the expected level follows from, so every cycle is checked at the edge where its result is due.

// File: rtl/act_led_pkg.sv
package act_led_pkg;

    typedef enum logic [1:0] {
        ST_DARK  = 2'd0,
        ST_LIT   = 2'd1,
        ST_FLASH = 2'd2,
        ST_JAM   = 2'd3
    } led_state_t;

    function automatic int half_cycles(input int clk_hz, input int blink_hz);
        return clk_hz / (2 * blink_hz);
    endfunction

    function automatic int stuck_cycles(input int clk_hz, input int stuck_us);
        return ((clk_hz / 1000) * stuck_us) / 1000;
    endfunction

endpackage

// File: rtl/act_led_prescaler.sv
module act_led_prescaler #(
    parameter int HALF_CYC = 1_250_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/act_led_col_watch.sv
module act_led_col_watch #(
    parameter int STUCK_CYC = 25_000
) (
    input  logic clk,
    input  logic rst,
    input  logic col,
    output logic stuck
);
    localparam int SW = $clog2(STUCK_CYC + 1);
    localparam logic [SW-1:0] LIMIT = SW'(STUCK_CYC);

    logic [SW-1:0] run_q;

    assign stuck = (run_q == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || !col) begin
            run_q <= '0;
        end else if (!stuck) begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/act_led_ctrl.sv
module act_led_ctrl
    import act_led_pkg::*;
#(
    parameter int CLK_HZ   = 25_000_000,
    parameter int BLINK_HZ = 10,
    parameter int STUCK_US = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic media_tp,
    input  logic link_ok,
    input  logic tx_busy,
    input  logic crs,
    input  logic col,
    output logic led
);
    localparam int HALF_CYC  = half_cycles(CLK_HZ, BLINK_HZ);
    localparam int STUCK_CYC = stuck_cycles(CLK_HZ, STUCK_US);

    led_state_t state_q, state_nx, settle_st;
    logic activity, blinking, tick, stuck;

    assign activity  = tx_busy | crs;
    assign blinking  = (state_q == ST_FLASH);
    assign settle_st = (media_tp && link_ok) ? ST_DARK : ST_LIT;

    act_led_prescaler #(.HALF_CYC(HALF_CYC)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (blinking),
        .tick (tick)
    );

    act_led_col_watch #(.STUCK_CYC(STUCK_CYC)) u_col (
        .clk   (clk),
        .rst   (rst),
        .col   (col),
        .stuck (stuck)
    );

    // next-state: start, tail, settle, release; jam overrides all
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_DARK, ST_LIT: state_nx = activity ? ST_FLASH : settle_st;
            ST_FLASH:        state_nx = !tick ? ST_FLASH
                                      : (activity ? ST_FLASH : settle_st);
            ST_JAM:          state_nx = activity ? ST_FLASH : settle_st;
            default:         state_nx = ST_LIT;
        endcase
        if (stuck) begin
            state_nx = ST_JAM;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LIT;
        end else begin
            state_q <= state_nx;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            led <= 1'b1;
        end else begin
            unique case (state_nx)
                ST_DARK:  led <= 1'b0;
                ST_LIT:   led <= 1'b1;
                ST_JAM:   led <= 1'b1;
                ST_FLASH: if (!blinking || tick) led <= ~led;
                default:  led <= 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/act_led_checker.sv
module act_led_checker (
    input logic clk,
    input logic rst,
    input logic media_tp,
    input logic link_ok,
    input logic tx_busy,
    input logic crs,
    input logic led,
    input logic blinking,
    input logic stuck,
    input logic tick
);
    p_reset_high_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> led);

    p_tp_good_dark_r2: assert property (@(posedge clk) disable iff (rst)
        (!blinking && !stuck && media_tp && link_ok && !tx_busy && !crs) |=> !led);

    p_tp_fail_lit_r3: assert property (@(posedge clk) disable iff (rst)
        (!blinking && !stuck && media_tp && !link_ok && !tx_busy && !crs) |=> led);

    p_aui_idle_lit_r4: assert property (@(posedge clk) disable iff (rst)
        (!blinking && !stuck && !media_tp && !tx_busy && !crs) |=> led);

    p_flash_start_r5: assert property (@(posedge clk) disable iff (rst)
        (!blinking && !stuck && (tx_busy || crs)) |=> (led != $past(led)));

    p_half_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (blinking && !tick && !stuck) |=> $stable(led));

    p_jam_lit_r7: assert property (@(posedge clk) disable iff (rst)
        stuck |=> led);

    p_tail_runs_r9: assert property (@(posedge clk) disable iff (rst)
        (blinking && !tick && !stuck && !tx_busy && !crs) |=> blinking);
endmodule

bind act_led_ctrl act_led_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .media_tp (media_tp),
    .link_ok  (link_ok),
    .tx_busy  (tx_busy),
    .crs      (crs),
    .led      (led),
    .blinking (blinking),
    .stuck    (stuck),
    .tick     (tick)
);

// File: tb/act_led_ctrl_test.sv
`timescale 1ns/1ps
module act_led_ctrl_test;
    localparam int CLK_HZ   = 4000;
    localparam int BLINK_HZ = 10;
    localparam int STUCK_US = 5000;
    localparam int HALF = CLK_HZ / (2 * BLINK_HZ);          // 200
    localparam int STK  = ((CLK_HZ / 1000) * STUCK_US) / 1000; // 20

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic media_tp = 1'b1, link_ok = 1'b1, tx_busy = 1'b0, crs = 1'b0, col = 1'b0;
    logic led;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    bit armed = 0;
    bit done = 0;

    // model state: 0 dark, 1 lit, 2 flash, 3 jam
    int  m_st = 1, m_nx = 1, m_cnt = 0, m_col = 0, m_base = 1;
    bit  m_led = 1, m_stk = 0, m_tk = 0, m_act = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    act_led_ctrl #(.CLK_HZ(CLK_HZ), .BLINK_HZ(BLINK_HZ), .STUCK_US(STUCK_US)) uut (
        .clk(clk), .rst(rst), .media_tp(media_tp), .link_ok(link_ok),
        .tx_busy(tx_busy), .crs(crs), .col(col), .led(led)
    );

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_st = 1; m_led = 1; m_cnt = 0; m_col = 0; tag = "R1"; armed = 1;
        end else begin
            m_stk  = (m_col >= STK);
            m_tk   = (m_st == 2) && (m_cnt == HALF - 1);
            m_act  = tx_busy || crs;
            m_base = (media_tp && link_ok) ? 0 : 1;
            if (m_stk) m_nx = 3;
            else if (m_st == 2 && !m_tk) m_nx = 2;
            else if (m_act) m_nx = 2;
            else m_nx = m_base;

            if (m_nx == 3) m_led = 1;
            else if (m_nx == 0) m_led = 0;
            else if (m_nx == 1) m_led = 1;
            else if (m_st != 2 || m_tk) m_led = !m_led;

            if (m_nx == 3) tag = "R7";
            else if (m_st == 3) tag = "R8";
            else if (m_nx == 2) begin
                if (m_st != 2) tag = "R5";
                else if (m_col > 0 || col) tag = "R10";
                else if (!m_act) tag = "R9";
                else tag = "R6";
            end else if (m_st == 2) tag = "R9";
            else if (m_nx == 0) tag = "R2";
            else if (media_tp) tag = "R3";
            else tag = "R4";

            if (m_st == 2 && !m_tk) m_cnt++; else m_cnt = 0;
            if (!col) m_col = 0; else if (m_col < STK) m_col++;
            m_st = m_nx;
        end
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (led !== m_led) begin
                errs++;
                $display("FAIL %s: led=%0b expected %0b at cycle %0d", tag, led, m_led, cyc);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(20);                       // R2 dark
        link_ok = 1'b0; wait_cyc(20);       // R3 lit
        media_tp = 1'b0; link_ok = 1'b1; wait_cyc(10);  // R4
        link_ok = 1'b0; wait_cyc(10);       // R4 link ignored
        media_tp = 1'b1; link_ok = 1'b1; wait_cyc(5);
        tx_busy = 1'b1; wait_cyc(3 * HALF + 50);   // R5, R6
        tx_busy = 1'b0; wait_cyc(HALF + 20);       // R9 tail
        crs = 1'b1; wait_cyc(HALF + 30);
        col = 1'b1; wait_cyc(STK - 5);             // R10 short burst
        col = 1'b0; wait_cyc(100);
        col = 1'b1; wait_cyc(STK + 30);            // R7 stuck
        col = 1'b0; wait_cyc(HALF);                // R8 release
        crs = 1'b0; wait_cyc(HALF + 10);
        col = 1'b1; wait_cyc(STK + 5);             // R7 while idle
        col = 1'b0; wait_cyc(10);                  // R8
        media_tp = 1'b0; crs = 1'b1; wait_cyc(2 * HALF + 7);
        crs = 1'b0; wait_cyc(HALF + 5);
        tx_busy = 1'b1; wait_cyc(HALF / 2);
        rst = 1'b1; wait_cyc(2);                   // R1 mid-blink reset
        rst = 1'b0; tx_busy = 1'b0; wait_cyc(20);
        media_tp = 1'b1; wait_cyc(10);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++; checks++;
            $display("FAIL watchdog: run did not end, expected end before cycle 100000");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule